// File: doc/BRIEF.md
# Clocked Sequencer for an Asynchronous Static RAM

This block sits between on-chip logic that issues single-word requests and an external static RAM that has no clock. A requester offers a request with a valid/ready handshake. The request carries a read/write flag, a word address, 16 bits of write data and a two-bit byte mask. The sequencer turns each accepted request into a timed sequence of active-low strobes on the memory pins: chip select, output enable, write strobe and one enable per byte lane. It holds each phase for a whole number of clock cycles. The three counts are parameters, chosen for the clock period so that the memory's access time, write-pulse width, data setup and output float time are all met.

Reads keep chip select, output enable and the chosen byte enables low for the access count. The data pins are sampled on the edge that ends the last access cycle, and the result is returned with a one-cycle valid pulse. Writes are ended by the write strobe. The strobe falls with the address and chip select. The sequencer then leaves the data pins undriven for a turnaround count, so that a memory whose output enable is wired low has time to float its outputs. It then drives data for the setup count, raises the write strobe, and keeps data, address and chip select for one more cycle as hold. The data pins are modelled as a separate output, an output-enable and an input, which the pad ring joins into a tri-state bus.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, all five memory strobes (`sram_ce_n`, `sram_oe_n`, `sram_we_n`, both bits of `sram_be_n`) are 1, `sram_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1, and only when no transfer is in progress. `req_ready` is 0 from the edge that takes a request until the transfer ends. A read keeps it low for RD_CYC cycles and a write for TA_CYC+WE_CYC+1 cycles. Whenever `req_ready` is 1, the memory is deselected.
- R3: A read holds `sram_ce_n` and `sram_oe_n` at 0, with `sram_we_n` at 1, for exactly RD_CYC cycles, starting with the cycle after the request is taken.
- R4: Read data is sampled from `sram_dq_in` on the edge that ends the last access cycle and is presented on `rsp_rdata`, with `rsp_valid` high for exactly one cycle. A byte lane whose mask bit is 0 reads as 8'h00.
- R5: A write holds `sram_we_n` at 0 for exactly TA_CYC+WE_CYC cycles, starting with the cycle after the request is taken. Throughout a write, `sram_oe_n` stays 1 and `sram_ce_n` is 0 whenever `sram_we_n` is 0.
- R6: During the first TA_CYC cycles of the write strobe, `sram_dq_oe` is 0. It then goes to 1 and presents the request's write data for the last WE_CYC cycles of the strobe.
- R7: For one cycle after `sram_we_n` rises, `sram_dq_oe` stays 1 and `sram_ce_n` stays 0. Both are released on the following edge, which also returns the block to idle.
- R8: `sram_oe_n` and `sram_dq_oe` are never active together. The data pins are released before the output enable of any later read falls.
- R9: `sram_addr` holds the taken request's address, unchanged, for every cycle in which `sram_ce_n` is 0.
- R10: Mask bit i set to 1 selects byte lane i, where lane 0 is data bits 7:0 and lane 1 is bits 15:8. While `sram_ce_n` is 0, `sram_be_n` equals the bitwise inverse of the mask, for reads and for writes.
- R11: A request offered while a transfer is in progress has no effect. The address, strobes and data pins of the current transfer are unchanged, and nothing is written for the offered request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_bmask | input | DW/8 | Byte lane select, bit i = lane i |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DW | Read data, unselected lanes zero |
| sram_addr | output | AW | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_be_n | output | DW/8 | Byte lane enables, active low |
| sram_dq_out | output | DW | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | DW | Data pins as seen from the memory |

## Verification
The assertions take for granted that all three phase counts are at least 1. They also assume that `req_valid` and the request fields are stable across the edge where they are sampled, and that reset is held for at least one edge before the first request. The bench changes inputs only on falling edges. It uses counts of 3, 2 and 2, so each phase lasts more than one cycle, and it pairs each request with an asynchronous memory model. That model writes on the rising edge of the write strobe and drives a fixed pattern on unselected lanes. Requests offered during a busy transfer are withdrawn on the falling edge where `req_ready` returns, so that they are never taken.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_WR_FLOAT = 3'd2,
    ST_WR_DRIVE = 3'd3,
    ST_WR_HOLD  = 3'd4
  } seq_state_e;

  // bits needed to hold values 0 .. maxv-1
  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int unsigned AW    = 18,
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_req,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_bmask,
  input  logic             cap_rd,
  input  logic [DW-1:0]    dq_in,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    wdata_q,
  output logic [DW-1:0]    rdata
);

  logic [LANES-1:0] bmask_q;
  logic [7:0]       lane_q [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      bmask_q <= '0;
    end else if (cap_req) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      bmask_q <= req_bmask;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q[l] <= '0;
      end else if (cap_rd) begin
        lane_q[l] <= bmask_q[l] ? dq_in[l*8 +: 8] : 8'h00;
      end
    end
    assign rdata[l*8 +: 8] = lane_q[l];
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned AW     = 18,
  parameter int unsigned DW     = 16,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned TA_CYC = 1,
  parameter int unsigned WE_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW/8-1:0]   req_bmask,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW-1:0]     sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DW/8-1:0]   sram_be_n,
  output logic [DW-1:0]     sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DW-1:0]     sram_dq_in
);

  localparam int unsigned LANES = DW / 8;
  localparam int unsigned MAXC  = max3(RD_CYC, TA_CYC, WE_CYC);
  localparam int unsigned CW    = cnt_width(MAXC);
  localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] TA_LD = CW'(TA_CYC - 1);
  localparam logic [CW-1:0] WE_LD = CW'(WE_CYC - 1);

  seq_state_e    state_q;
  logic          accept;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;
  logic          cap_rd;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cap_rd    = (state_q == ST_RD_ACC) && tmr_done;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = req_write ? TA_LD : RD_LD;
    end else if (state_q == ST_WR_FLOAT && tmr_done) begin
      tmr_load = 1'b1;
      tmr_val  = WE_LD;
    end
  end

  sram_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  sram_seq_dpath #(.AW(AW), .DW(DW), .LANES(LANES)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .cap_req   (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_bmask (req_bmask),
    .cap_rd    (cap_rd),
    .dq_in     (sram_dq_in),
    .addr_q    (sram_addr),
    .wdata_q   (sram_dq_out),
    .rdata     (rsp_rdata)
  );

  // sequencer with registered strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sram_ce_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_be_n  <= '1;
      sram_dq_oe <= 1'b0;
      rsp_valid  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            sram_ce_n <= 1'b0;
            sram_be_n <= ~req_bmask;
            if (req_write) begin
              sram_we_n <= 1'b0;
              state_q   <= ST_WR_FLOAT;
            end else begin
              sram_oe_n <= 1'b0;
              state_q   <= ST_RD_ACC;
            end
          end
        end
        ST_RD_ACC: begin
          if (tmr_done) begin
            sram_ce_n <= 1'b1;
            sram_oe_n <= 1'b1;
            sram_be_n <= '1;
            rsp_valid <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_WR_FLOAT: begin
          if (tmr_done) begin
            sram_dq_oe <= 1'b1;
            state_q    <= ST_WR_DRIVE;
          end
        end
        ST_WR_DRIVE: begin
          if (tmr_done) begin
            sram_we_n <= 1'b1;
            state_q   <= ST_WR_HOLD;
          end
        end
        ST_WR_HOLD: begin
          sram_ce_n  <= 1'b1;
          sram_be_n  <= '1;
          sram_dq_oe <= 1'b0;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checks on the pin sequence
  assert_idle_deselected_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_we_inside_ce_R5: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n));

  assert_float_before_drive_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (!sram_we_n && $past(!sram_we_n)));

  assert_hold_after_we_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce_n));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> !sram_dq_oe);

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  assert_be_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_be_n));

endmodule

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;

  localparam int PERIOD = 10;
  localparam int AW = 18;
  localparam int RD = 3;
  localparam int TA = 2;
  localparam int WE = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic [1:0]    req_bmask;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [1:0]    sram_be_n;
  logic [15:0]   sram_dq_out, sram_dq_in;

  int vectors = 0;
  int misses  = 0;

  always #(PERIOD/2) clk = ~clk;

  sram_seq_ctrl #(.AW(AW), .DW(16), .RD_CYC(RD), .TA_CYC(TA), .WE_CYC(WE)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // asynchronous memory model, 16 words
  logic [15:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = 16'h0000;

  always @(posedge sram_we_n) begin
    if (sram_ce_n === 1'b0 && sram_dq_oe === 1'b1) begin
      if (!sram_be_n[0]) mem[sram_addr[3:0]][7:0]  <= sram_dq_out[7:0];
      if (!sram_be_n[1]) mem[sram_addr[3:0]][15:8] <= sram_dq_out[15:8];
    end
  end

  assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ?
    {sram_be_n[1] ? 8'h5A : mem[sram_addr[3:0]][15:8],
     sram_be_n[0] ? 8'hC3 : mem[sram_addr[3:0]][7:0]} : 16'hFFFF;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-transfer observations, indices count falling edges after the accepting edge
  int ce_cnt, oe_cnt, we_cnt, rdy_low, first_drv, last_drv, we_rise, rsp_idx, done_idx;
  int clash, addr_bad, be_bad, drv_bad, rsp_cnt;
  logic [15:0] rd_seen;

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit poke);
    logic we_was_low;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
    @(negedge clk);
    req_valid = 1'b0;
    ce_cnt = 0; oe_cnt = 0; we_cnt = 0; rdy_low = 0; first_drv = 0; last_drv = 0;
    we_rise = 0; rsp_idx = 0; done_idx = 0; clash = 0; addr_bad = 0; be_bad = 0;
    drv_bad = 0; rsp_cnt = 0; rd_seen = 16'h0; we_was_low = 1'b0;
    if (poke) begin
      req_valid = 1'b1; req_write = ~wr; req_addr = a ^ 18'h0000C;
      req_wdata = 16'hBEEF; req_bmask = 2'b11;
    end
    for (int i = 1; i <= 40; i++) begin
      if (!sram_ce_n) begin
        ce_cnt++;
        if (sram_addr !== a) addr_bad++;
        if (sram_be_n !== ~m) be_bad++;
      end
      if (!sram_oe_n) oe_cnt++;
      if (!sram_we_n) begin
        we_cnt++;
        we_was_low = 1'b1;
      end else if (we_was_low && we_rise == 0) begin
        we_rise = i;
      end
      if (sram_dq_oe) begin
        if (first_drv == 0) first_drv = i;
        last_drv = i;
        if (sram_dq_out !== d) drv_bad++;
      end
      if (sram_dq_oe && !sram_oe_n) clash++;
      if (rsp_valid) begin
        rsp_cnt++;
        if (rsp_idx == 0) begin
          rsp_idx = i;
          rd_seen = rsp_rdata;
        end
      end
      if (!req_ready) rdy_low++;
      if (req_ready) begin
        done_idx = i;
        req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
    // one more cycle to confirm the response pulse is single
    if (!wr) begin
      @(negedge clk);
      if (rsp_valid) rsp_cnt++;
    end
  endtask

  task automatic t_reset;
    check(req_ready === 1'b1, "R1 ready", req_ready, 1);
    check({sram_ce_n, sram_oe_n, sram_we_n, sram_be_n} === 5'b11111, "R1 strobes",
          {sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}, 5'h1F);
    check(sram_dq_oe === 1'b0, "R1 dq_oe", sram_dq_oe, 0);
    check(rsp_valid === 1'b0, "R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_write_full;
    issue(1'b1, 18'h00003, 16'h1234, 2'b11, 1'b0);
    check(we_cnt == TA + WE, "R5 we low cycles", we_cnt, TA + WE);
    check(oe_cnt == 0, "R5 oe during write", oe_cnt, 0);
    check(ce_cnt == TA + WE + 1, "R7 ce low cycles", ce_cnt, TA + WE + 1);
    check(first_drv == TA + 1, "R6 first drive", first_drv, TA + 1);
    check(last_drv == TA + WE + 1, "R7 last drive", last_drv, TA + WE + 1);
    check(we_rise == TA + WE + 1, "R7 we rise", we_rise, TA + WE + 1);
    check(drv_bad == 0, "R6 driven data", drv_bad, 0);
    check(done_idx == TA + WE + 2, "R2 write ready return", done_idx, TA + WE + 2);
    check(addr_bad == 0, "R9 write address", addr_bad, 0);
    check(be_bad == 0, "R10 write byte enables", be_bad, 0);
    check(mem[3] === 16'h1234, "R5 stored word", mem[3], 16'h1234);
  endtask

  task automatic t_read_full;
    issue(1'b0, 18'h00003, 16'h0000, 2'b11, 1'b0);
    check(ce_cnt == RD, "R3 ce low cycles", ce_cnt, RD);
    check(oe_cnt == RD, "R3 oe low cycles", oe_cnt, RD);
    check(we_cnt == 0, "R3 we during read", we_cnt, 0);
    check(rsp_idx == RD + 1, "R4 rsp timing", rsp_idx, RD + 1);
    check(rsp_cnt == 1, "R4 single pulse", rsp_cnt, 1);
    check(rd_seen === 16'h1234, "R4 read data", rd_seen, 16'h1234);
    check(rdy_low == RD, "R2 read busy cycles", rdy_low, RD);
    check(clash == 0, "R8 read contention", clash, 0);
  endtask

  task automatic t_byte_lanes;
    issue(1'b1, 18'h20005, 16'hFFFF, 2'b11, 1'b0);
    issue(1'b1, 18'h20005, 16'h12AB, 2'b01, 1'b0);
    check(be_bad == 0, "R10 low-lane enables", be_bad, 0);
    check(mem[5] === 16'hFFAB, "R10 low-lane write", mem[5], 16'hFFAB);
    issue(1'b0, 18'h20005, 16'h0000, 2'b10, 1'b0);
    check(be_bad == 0, "R10 high-lane read enables", be_bad, 0);
    check(rd_seen === 16'hFF00, "R4 masked lane zero", rd_seen, 16'hFF00);
    issue(1'b0, 18'h20005, 16'h0000, 2'b01, 1'b0);
    check(rd_seen === 16'h00AB, "R4 low lane only", rd_seen, 16'h00AB);
  endtask

  task automatic t_turnaround;
    issue(1'b1, 18'h00007, 16'hA55A, 2'b11, 1'b0);
    check(clash == 0, "R8 write then read, write side", clash, 0);
    issue(1'b0, 18'h00007, 16'h0000, 2'b11, 1'b0);
    check(clash == 0, "R8 write then read, read side", clash, 0);
    check(first_drv == 0, "R8 bus released on read", first_drv, 0);
    check(rd_seen === 16'hA55A, "R8 back-to-back data", rd_seen, 16'hA55A);
  endtask

  task automatic t_busy_ignore;
    // read of word 3 with a write to word 15 offered while busy
    issue(1'b0, 18'h00003, 16'h0000, 2'b11, 1'b1);
    check(addr_bad == 0, "R11 address kept", addr_bad, 0);
    check(we_cnt == 0, "R11 no write strobe", we_cnt, 0);
    check(rd_seen === 16'h1234, "R11 read unaffected", rd_seen, 16'h1234);
    issue(1'b0, 18'h0000F, 16'h0000, 2'b11, 1'b0);
    check(rd_seen === 16'h0000, "R11 offered write not stored", rd_seen, 16'h0000);
  endtask

  initial begin
    #(PERIOD * 50000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_bmask = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_full();
    t_read_full();
    t_byte_lanes();
    t_turnaround();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule